// File: doc/BRIEF.md
# Injected Channel Conversion Sequencer

This block runs a short, high-priority group of converter channels. The group holds one to four ranks. Each rank names a channel through a 5-bit field of a packed sequence word, and has its own sampling time and offset. A conversion starts on a software pulse, on a selectable edge of an external trigger, or, in auto-start mode, when the regular group reports that it has finished. The block drives an abstract converter core over a start/done handshake. It counts the exact conversion time, subtracts the rank's offset from the raw result and stores the signed value in that rank's slot.

The channel list is right-aligned in the sequence word, so the final rank always occupies the top field. In discontinuous mode, each trigger advances the group by one rank. When scanning is off, only the first rank is converted. A sticky end-of-sequence flag marks completion of the group and is cleared by a write of one.

Top module: `prio_group_seq`

## Requirements
- R1: After reset, `conv_start` and `eos` are 0 and every result slot reads 0.
- R2: With length L (`cfg_len_m1` = L-1), rank r (1..L) uses the 5-bit field at index r+3-L, which is bits [5i+4:5i] of `cfg_seq`. A sequence therefore begins at field 4-L and ends at field 3.
- R3: A result is taken only when `conv_done` is high at least S+P cycles after the `conv_start` cycle. S is the rank's sample count. P is 12, 11, 9 or 7 for `cfg_res` codes 00 (12 bit), 01 (10 bit), 10 (8 bit) and 11 (6 bit). A `conv_done` that arrives earlier is ignored.
- R4: The slot for rank r (`res_flat` bits [16(r-1)+15:16(r-1)]) receives the raw data minus the offset of rank r (`cfg_off` bits [12(r-1)+11:12(r-1)]). The offset is first masked to 0xFFF, 0x3FF, 0xFF or 0x3F by resolution, and the difference is sign-extended to 16 bits.
- R5: `cfg_edge` selects the external trigger edge: 00 none, 01 rising, 10 falling, 11 both. The trigger input passes through a two-flop synchroniser.
- R6: When `cfg_sw_only` is 1, the external trigger input has no effect. `sw_start` starts the group in every configuration.
- R7: With scanning and discontinuous mode both on, each trigger converts exactly one rank. The next trigger continues with the following rank, and the rank after the final one is the first rank again.
- R8: With scanning off, a trigger converts only the first rank (field 4-L) and discontinuous mode has no effect.
- R9: A `reg_done` pulse starts the full group only when auto mode is on, discontinuous mode is off and external triggering is disabled (`cfg_sw_only` = 1 or `cfg_edge` = 00). In any other configuration it is ignored.
- R10: A trigger that arrives while a conversion sequence is running is ignored.
- R11: `eos` sets one cycle after the final rank's result is taken. It stays set until `eos_clr` is 1, and setting takes priority over clearing.
- R12: `conv_start` is a one-cycle pulse per rank. While it is high, `conv_smp` carries that rank's sample count (`cfg_smp` bits [8(r-1)+7:8(r-1)]) and `conv_res` carries `cfg_res`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_seq | input | 20 | Four 5-bit channel fields, right-aligned by length |
| cfg_len_m1 | input | 2 | Sequence length minus one |
| cfg_off | input | 48 | Four 12-bit per-rank offsets |
| cfg_smp | input | 32 | Four 8-bit per-rank sample counts |
| cfg_res | input | 2 | Resolution code |
| cfg_edge | input | 2 | External trigger edge select |
| cfg_sw_only | input | 1 | Disable the external trigger |
| cfg_scan | input | 1 | Scan enable |
| cfg_disc | input | 1 | Discontinuous (one rank per trigger) mode |
| cfg_auto | input | 1 | Auto-start after the regular group |
| sw_start | input | 1 | Software start pulse |
| ext_trig | input | 1 | Asynchronous external trigger |
| reg_done | input | 1 | Regular-group completion pulse |
| conv_start | output | 1 | Converter start pulse |
| conv_chan | output | 5 | Channel to convert |
| conv_smp | output | 8 | Sample cycles for this conversion |
| conv_res | output | 2 | Resolution for this conversion |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 12 | Raw converter result |
| res_flat | output | 64 | Four 16-bit signed corrected results |
| eos | output | 1 | Sticky end-of-sequence flag |
| eos_clr | input | 1 | Write-one clear for `eos` |

## Verification
The bench builds the block with the package defaults: four ranks, 5-bit channels, 12-bit raw data, 16-bit results and 8-bit sample counts. With a full-width offset of 0xFFF, a negative corrected result is reachable. The full four-field right alignment and all four resolution codes are also reachable, so every processing-cycle count and offset mask is exercised. A converter model answers at exactly S+P cycles, and in one mode it first presents a false early `conv_done`. This exposes both a timer that runs short, which captures the false data, and a timer that runs long, which misses the answer and stalls.

// File: rtl/prio_seq_pkg.sv
package prio_seq_pkg;

    localparam int unsigned NRANK = 4;
    localparam int unsigned CHW   = 5;
    localparam int unsigned DW    = 12;
    localparam int unsigned RW    = 16;
    localparam int unsigned SMPW  = 8;
    localparam int unsigned RKW   = $clog2(NRANK);

    typedef enum logic [1:0] {
        RES12 = 2'b00,
        RES10 = 2'b01,
        RES8  = 2'b10,
        RES6  = 2'b11
    } res_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } st_e;

    typedef struct packed {
        logic [RKW-1:0] rank;
        logic [DW-1:0]  data;
        logic           last;
    } capt_t;

    function automatic logic [4:0] proc_cycles(res_e r);
        case (r)
            RES12:   return 5'd12;
            RES10:   return 5'd11;
            RES8:    return 5'd9;
            default: return 5'd7;
        endcase
    endfunction

    function automatic logic [DW-1:0] res_mask(res_e r);
        case (r)
            RES12:   return DW'(12'hFFF);
            RES10:   return DW'(12'h3FF);
            RES8:    return DW'(12'h0FF);
            default: return DW'(12'h03F);
        endcase
    endfunction

endpackage

// File: rtl/prio_trig_sync.sv
module prio_trig_sync
    import prio_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_in,
    input  logic [1:0] edge_sel,
    input  logic       sw_only,
    output logic       ext_evt
);
    logic s1_q, s2_q, prev_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= ext_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    always_comb begin
        rise    = s2_q & ~prev_q;
        fall    = ~s2_q & prev_q;
        ext_evt = 1'b0;
        if (!sw_only) begin
            case (edge_e'(edge_sel))
                EDGE_RISE: ext_evt = rise;
                EDGE_FALL: ext_evt = fall;
                EDGE_BOTH: ext_evt = rise | fall;
                default:   ext_evt = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/prio_rank_ctrl.sv
module prio_rank_ctrl
    import prio_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_evt,
    input  logic [NRANK*CHW-1:0]  cfg_seq,
    input  logic [RKW-1:0]        cfg_len_m1,
    input  logic [NRANK*SMPW-1:0] cfg_smp,
    input  logic [1:0]            cfg_res,
    input  logic                  cfg_scan,
    input  logic                  cfg_disc,
    input  logic                  conv_done,
    input  logic [DW-1:0]         conv_data,
    output logic                  conv_start,
    output logic [CHW-1:0]        conv_chan,
    output logic [SMPW-1:0]       conv_smp,
    output logic                  cap_vld,
    output capt_t                 cap
);
    st_e            st_q;
    logic [RKW-1:0] rank_q, pos_q;
    logic [SMPW:0]  wait_q;
    logic           start_q;

    logic           step_mode, is_last;
    logic [RKW-1:0] last_rank, first_rank, next_rank, fld;

    function automatic logic [SMPW:0] load_for(logic [RKW-1:0] r);
        return {1'b0, cfg_smp[r*SMPW +: SMPW]} + (SMPW+1)'(proc_cycles(res_e'(cfg_res)));
    endfunction

    always_comb begin
        step_mode  = cfg_disc & cfg_scan;
        last_rank  = cfg_scan ? cfg_len_m1 : '0;
        is_last    = step_mode ? (rank_q == cfg_len_m1) : (rank_q == last_rank);
        first_rank = step_mode ? pos_q : '0;
        next_rank  = rank_q + 1'b1;
        // right alignment: final rank always lands in the top field
        fld        = rank_q + (RKW'(NRANK-1) - cfg_len_m1);
        conv_chan  = cfg_seq[fld*CHW +: CHW];
        conv_smp   = cfg_smp[rank_q*SMPW +: SMPW];
        conv_start = start_q;
        cap_vld    = (st_q == ST_CONV) && (wait_q == '0) && conv_done;
        cap.rank   = rank_q;
        cap.data   = conv_data;
        cap.last   = is_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            rank_q  <= '0;
            pos_q   <= '0;
            wait_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_evt) begin
                        rank_q  <= first_rank;
                        wait_q  <= load_for(first_rank);
                        start_q <= 1'b1;
                        st_q    <= ST_CONV;
                    end
                end
                default: begin
                    if (wait_q != '0) begin
                        wait_q <= wait_q - 1'b1;
                    end else if (conv_done) begin
                        if (!step_mode && !is_last) begin
                            rank_q  <= next_rank;
                            wait_q  <= load_for(next_rank);
                            start_q <= 1'b1;
                        end else begin
                            st_q <= ST_IDLE;
                            if (step_mode)
                                pos_q <= is_last ? '0 : next_rank;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/prio_result_bank.sv
module prio_result_bank
    import prio_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cap_vld,
    input  capt_t                cap,
    input  logic [1:0]           cfg_res,
    input  logic [NRANK*DW-1:0]  cfg_off,
    input  logic                 eos_clr,
    output logic [NRANK*RW-1:0]  res_flat,
    output logic                 eos
);
    logic [DW-1:0] off_m;
    logic [DW:0]   diff;
    logic [RW-1:0] corr;

    always_comb begin
        off_m = cfg_off[cap.rank*DW +: DW] & res_mask(res_e'(cfg_res));
        diff  = {1'b0, cap.data} - {1'b0, off_m};
        corr  = {{(RW-DW-1){diff[DW]}}, diff};
    end

    for (genvar g = 0; g < NRANK; g++) begin : g_slot
        logic [RW-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (cap_vld && (cap.rank == RKW'(g)))
                slot_q <= corr;
        end
        assign res_flat[g*RW +: RW] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            eos <= 1'b0;
        else if (cap_vld && cap.last)
            eos <= 1'b1;
        else if (eos_clr)
            eos <= 1'b0;
    end
endmodule

// File: rtl/prio_group_seq.sv
module prio_group_seq
    import prio_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NRANK*CHW-1:0]  cfg_seq,
    input  logic [RKW-1:0]        cfg_len_m1,
    input  logic [NRANK*DW-1:0]   cfg_off,
    input  logic [NRANK*SMPW-1:0] cfg_smp,
    input  logic [1:0]            cfg_res,
    input  logic [1:0]            cfg_edge,
    input  logic                  cfg_sw_only,
    input  logic                  cfg_scan,
    input  logic                  cfg_disc,
    input  logic                  cfg_auto,
    input  logic                  sw_start,
    input  logic                  ext_trig,
    input  logic                  reg_done,
    output logic                  conv_start,
    output logic [CHW-1:0]        conv_chan,
    output logic [SMPW-1:0]       conv_smp,
    output logic [1:0]            conv_res,
    input  logic                  conv_done,
    input  logic [DW-1:0]         conv_data,
    output logic [NRANK*RW-1:0]   res_flat,
    output logic                  eos,
    input  logic                  eos_clr
);
    logic  ext_evt, auto_evt, start_evt;
    logic  cap_vld, cap_last;
    capt_t cap;

    prio_trig_sync u_trig (
        .clk      (clk),
        .rst      (rst),
        .ext_in   (ext_trig),
        .edge_sel (cfg_edge),
        .sw_only  (cfg_sw_only),
        .ext_evt  (ext_evt)
    );

    // auto chaining is honoured only with no sub-stepping and no external source
    assign auto_evt  = cfg_auto & ~cfg_disc & (cfg_sw_only | (cfg_edge == 2'b00)) & reg_done;
    assign start_evt = sw_start | ext_evt | auto_evt;
    assign conv_res  = cfg_res;
    assign cap_last  = cap.last;

    prio_rank_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_evt  (start_evt),
        .cfg_seq    (cfg_seq),
        .cfg_len_m1 (cfg_len_m1),
        .cfg_smp    (cfg_smp),
        .cfg_res    (cfg_res),
        .cfg_scan   (cfg_scan),
        .cfg_disc   (cfg_disc),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .conv_smp   (conv_smp),
        .cap_vld    (cap_vld),
        .cap        (cap)
    );

    prio_result_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .cap_vld  (cap_vld),
        .cap      (cap),
        .cfg_res  (cfg_res),
        .cfg_off  (cfg_off),
        .eos_clr  (eos_clr),
        .res_flat (res_flat),
        .eos      (eos)
    );
endmodule

// File: rtl/prio_seq_chk.sv
module prio_seq_chk
    import prio_seq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            conv_start,
    input logic [SMPW-1:0] conv_smp,
    input logic [1:0]      conv_res,
    input logic            cap_vld,
    input logic            cap_last,
    input logic            eos,
    input logic            eos_clr
);
    logic [15:0] since_q, need_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            need_q  <= '0;
        end else if (conv_start) begin
            since_q <= 16'd1;
            need_q  <= 16'(conv_smp) + 16'(proc_cycles(res_e'(conv_res)));
        end else if (since_q != 16'hFFFF) begin
            since_q <= since_q + 16'd1;
        end
    end

    p_min_wait_r3: assert property (@(posedge clk) disable iff (rst)
        cap_vld |-> (since_q >= need_q));

    p_start_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    p_eos_set_r11: assert property (@(posedge clk) disable iff (rst)
        (cap_vld && cap_last) |=> eos);

    p_eos_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (eos && !eos_clr) |=> eos);

    p_eos_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (eos_clr && !(cap_vld && cap_last)) |=> !eos);
endmodule

bind prio_group_seq prio_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .conv_smp   (conv_smp),
    .conv_res   (conv_res),
    .cap_vld    (cap_vld),
    .cap_last   (cap_last),
    .eos        (eos),
    .eos_clr    (eos_clr)
);

// File: tb/prio_group_seq_tb_top.sv
module prio_group_seq_tb_top;
    import prio_seq_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic [19:0] cfg_seq;
    logic [1:0]  cfg_len_m1;
    logic [47:0] cfg_off;
    logic [31:0] cfg_smp;
    logic [1:0]  cfg_res, cfg_edge;
    logic        cfg_sw_only, cfg_scan, cfg_disc, cfg_auto;
    logic        sw_start, ext_trig, reg_done, eos_clr;
    logic        conv_start, conv_done, eos;
    logic [4:0]  conv_chan;
    logic [7:0]  conv_smp;
    logic [1:0]  conv_res;
    logic [11:0] conv_data;
    logic [63:0] res_flat;

    prio_group_seq dut_i (
        .clk(clk), .rst(rst), .cfg_seq(cfg_seq), .cfg_len_m1(cfg_len_m1),
        .cfg_off(cfg_off), .cfg_smp(cfg_smp), .cfg_res(cfg_res), .cfg_edge(cfg_edge),
        .cfg_sw_only(cfg_sw_only), .cfg_scan(cfg_scan), .cfg_disc(cfg_disc),
        .cfg_auto(cfg_auto), .sw_start(sw_start), .ext_trig(ext_trig),
        .reg_done(reg_done), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_smp(conv_smp), .conv_res(conv_res), .conv_done(conv_done),
        .conv_data(conv_data), .res_flat(res_flat), .eos(eos), .eos_clr(eos_clr)
    );

    int n_chk = 0, n_fail = 0, n_conv = 0;
    int chan_log[0:31];
    int smp_log[0:31];
    int rlog[0:31];
    bit early_mode = 1'b0;
    bit ended = 1'b0;

    function automatic int dval(int ch);
        return ch * 100 + 40;
    endfunction

    function automatic int proc_ref(int r);
        case (r)
            0: return 12;
            1: return 11;
            2: return 9;
            default: return 7;
        endcase
    endfunction

    function automatic int exp_res(int ch, int off, int r);
        int m;
        logic [15:0] v;
        case (r)
            0: m = 'hFFF;
            1: m = 'h3FF;
            2: m = 'h0FF;
            default: m = 'h03F;
        endcase
        v = 16'(dval(ch) - (off & m));
        return int'(v);
    endfunction

    function automatic int slot(int r);
        return int'(res_flat[r*16 +: 16]);
    endfunction

    task automatic check(string req, string what, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    // converter core model: answers exactly S+P cycles after the start cycle
    initial begin
        conv_done = 1'b0;
        conv_data = '0;
        @(negedge clk);
        forever begin
            if (conv_start) begin
                int ch, n;
                ch = int'(conv_chan);
                n  = int'(conv_smp) + proc_ref(int'(conv_res));
                if (n_conv < 32) begin
                    chan_log[n_conv] = ch;
                    smp_log[n_conv]  = int'(conv_smp);
                    rlog[n_conv]     = int'(conv_res);
                end
                n_conv++;
                if (early_mode) begin
                    repeat (n - 1) @(negedge clk);
                    conv_done = 1'b1;
                    conv_data = 12'hABC;
                    @(negedge clk);
                    conv_done = 1'b0;
                    repeat (2) @(negedge clk);
                end else begin
                    repeat (n) @(negedge clk);
                end
                conv_done = 1'b1;
                conv_data = 12'(dval(ch));
                @(negedge clk);
                conv_done = 1'b0;
                conv_data = '0;
            end else begin
                @(negedge clk);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sw();
        sw_start = 1'b1; @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic pulse_reg();
        reg_done = 1'b1; @(negedge clk); reg_done = 1'b0;
    endtask

    task automatic pulse_clr();
        eos_clr = 1'b1; @(negedge clk); eos_clr = 1'b0;
    endtask

    task automatic set_fields(int f0, int f1, int f2, int f3);
        cfg_seq = {5'(f3), 5'(f2), 5'(f1), 5'(f0)};
    endtask

    task automatic wait_eos(int lim, string req);
        int k = 0;
        while (!eos && k < lim) begin
            @(negedge clk);
            k++;
        end
        check(req, "eos after sequence", int'(eos), 1);
    endtask

    task automatic t_reset();
        check("R1", "conv_start after reset", int'(conv_start), 0);
        check("R1", "eos after reset", int'(eos), 0);
        check("R1", "results after reset", int'(res_flat == '0), 1);
    endtask

    task automatic t_full_seq();
        int base;
        cfg_scan = 1; cfg_disc = 0; cfg_len_m1 = 2'd3; cfg_res = 2'b00;
        set_fields(3, 7, 12, 20);
        cfg_off = {12'hFFF, 12'h000, 12'h200, 12'h00A};
        cfg_smp = {8'd5, 8'd2, 8'd9, 8'd4};
        base = n_conv;
        pulse_sw();
        wait_eos(2000, "R11");
        wait_cyc(2);
        check("R2", "conversions of length-4 group", n_conv - base, 4);
        check("R2", "rank1 channel", chan_log[base], 3);
        check("R2", "rank2 channel", chan_log[base+1], 7);
        check("R2", "rank3 channel", chan_log[base+2], 12);
        check("R2", "rank4 channel", chan_log[base+3], 20);
        check("R12", "rank1 sample count", smp_log[base], 4);
        check("R12", "rank4 sample count", smp_log[base+3], 5);
        check("R4", "rank1 result", slot(0), exp_res(3, 'h00A, 0));
        check("R4", "rank2 result", slot(1), exp_res(7, 'h200, 0));
        check("R4", "rank3 result", slot(2), exp_res(12, 0, 0));
        check("R4", "rank4 negative result", slot(3), exp_res(20, 'hFFF, 0));
        wait_cyc(5);
        check("R11", "eos stays set", int'(eos), 1);
        pulse_clr();
        check("R11", "eos cleared by write one", int'(eos), 0);
    endtask

    task automatic t_short_len();
        int base;
        cfg_len_m1 = 2'd1;
        set_fields(1, 2, 9, 17);
        cfg_off = '0;
        cfg_smp = {8'd0, 8'd0, 8'd3, 8'd6};
        base = n_conv;
        pulse_sw();
        wait_eos(2000, "R2");
        wait_cyc(2);
        check("R2", "conversions of length-2 group", n_conv - base, 2);
        check("R2", "length-2 first channel from field 2", chan_log[base], 9);
        check("R2", "length-2 last channel from top field", chan_log[base+1], 17);
        check("R12", "length-2 rank2 sample count", smp_log[base+1], 3);
        pulse_clr();
    endtask

    task automatic t_res_offset(int r, int off, string tag);
        int base;
        cfg_len_m1 = 2'd0; cfg_res = 2'(r);
        set_fields(0, 0, 0, 5);
        cfg_off = {36'h0, 12'(off)};
        cfg_smp = {24'h0, 8'd6};
        early_mode = 1'b1;
        base = n_conv;
        pulse_sw();
        wait_eos(2000, "R3");
        wait_cyc(2);
        early_mode = 1'b0;
        check("R3", {tag, " early done ignored, result"}, slot(0), exp_res(5, off, r));
        check("R4", {tag, " single conversion"}, n_conv - base, 1);
        check("R12", {tag, " resolution on handshake"}, rlog[base], r);
        pulse_clr();
    endtask

    task automatic t_busy();
        int base;
        cfg_len_m1 = 2'd3; cfg_res = 2'b00;
        set_fields(1, 2, 3, 4);
        cfg_smp = {8'd20, 8'd20, 8'd20, 8'd20};
        base = n_conv;
        pulse_sw();
        wait_cyc(5);
        pulse_sw();
        wait_cyc(30);
        pulse_sw();
        wait_eos(3000, "R10");
        wait_cyc(100);
        check("R10", "triggers during sequence ignored", n_conv - base, 4);
        pulse_clr();
    endtask

    task automatic ext_step(int e, bit v, int expd, string req, string what);
        int base;
        cfg_edge = 2'(e);
        wait_cyc(2);
        base = n_conv;
        ext_trig = v;
        wait_cyc(40);
        check(req, what, n_conv - base, expd);
    endtask

    task automatic t_edges();
        int base;
        cfg_len_m1 = 2'd0; cfg_scan = 1; cfg_disc = 0;
        set_fields(0, 0, 0, 6);
        cfg_smp = {24'h0, 8'd3};
        cfg_sw_only = 0;
        ext_step(1, 1, 1, "R5", "rising select, rising edge");
        ext_step(1, 0, 0, "R5", "rising select, falling edge");
        ext_step(2, 1, 0, "R5", "falling select, rising edge");
        ext_step(2, 0, 1, "R5", "falling select, falling edge");
        ext_step(3, 1, 1, "R5", "both select, rising edge");
        ext_step(3, 0, 1, "R5", "both select, falling edge");
        ext_step(0, 1, 0, "R5", "edge off, rising edge");
        ext_step(0, 0, 0, "R5", "edge off, falling edge");
        cfg_sw_only = 1;
        ext_step(3, 1, 0, "R6", "software-only, rising edge");
        ext_step(3, 0, 0, "R6", "software-only, falling edge");
        base = n_conv;
        pulse_sw();
        wait_cyc(40);
        check("R6", "software start with software-only", n_conv - base, 1);
        cfg_edge = 2'b00;
        pulse_clr();
    endtask

    task automatic t_disc();
        int base;
        cfg_scan = 1; cfg_disc = 1; cfg_len_m1 = 2'd2; cfg_res = 2'b00;
        set_fields(1, 11, 13, 15);
        cfg_off = {12'h0, 12'h0, 12'h0, 12'h010};
        cfg_smp = {8'd2, 8'd2, 8'd2, 8'd2};
        pulse_clr();
        base = n_conv;
        pulse_sw(); wait_cyc(40);
        check("R7", "one rank per trigger (1st)", n_conv - base, 1);
        check("R7", "first step channel", chan_log[base], 11);
        check("R7", "eos not set after first step", int'(eos), 0);
        check("R7", "first step result", slot(0), exp_res(11, 'h010, 0));
        pulse_sw(); wait_cyc(40);
        check("R7", "second step channel", chan_log[base+1], 13);
        check("R7", "eos not set after second step", int'(eos), 0);
        pulse_sw(); wait_cyc(40);
        check("R7", "third step channel", chan_log[base+2], 15);
        check("R11", "eos after final step", int'(eos), 1);
        pulse_sw(); wait_cyc(40);
        check("R7", "wrap to first rank", chan_log[base+3], 11);
        check("R7", "total steps", n_conv - base, 4);
        pulse_clr();
    endtask

    task automatic t_scan_off();
        int base;
        cfg_scan = 0; cfg_disc = 1; cfg_len_m1 = 2'd2;
        set_fields(30, 22, 24, 26);
        cfg_off = {12'h0, 12'h0, 12'h0, 12'h005};
        base = n_conv;
        pulse_sw(); wait_cyc(60);
        check("R8", "scan off converts one rank", n_conv - base, 1);
        check("R8", "scan off channel from field 4-L", chan_log[base], 22);
        check("R8", "scan off sets eos", int'(eos), 1);
        check("R8", "scan off result in rank1 slot", slot(0), exp_res(22, 5, 0));
        pulse_clr();
        pulse_sw(); wait_cyc(60);
        check("R8", "scan off repeats first rank", chan_log[base+1], 22);
        pulse_clr();
    endtask

    task automatic t_auto();
        int base;
        cfg_scan = 1; cfg_disc = 0; cfg_len_m1 = 2'd1; cfg_auto = 1;
        cfg_sw_only = 1; cfg_edge = 2'b01;
        set_fields(0, 0, 4, 8);
        base = n_conv;
        pulse_reg();
        wait_eos(2000, "R9");
        wait_cyc(2);
        check("R9", "auto start runs full group", n_conv - base, 2);
        check("R9", "auto start last channel", chan_log[base+1], 8);
        pulse_clr();
        cfg_disc = 1;
        base = n_conv;
        pulse_reg(); wait_cyc(60);
        check("R9", "auto ignored with discontinuous", n_conv - base, 0);
        cfg_disc = 0; cfg_sw_only = 0; cfg_edge = 2'b01;
        base = n_conv;
        pulse_reg(); wait_cyc(60);
        check("R9", "auto ignored with external edge", n_conv - base, 0);
        cfg_edge = 2'b00;
        base = n_conv;
        pulse_reg(); wait_cyc(80);
        check("R9", "auto with edge field off", n_conv - base, 2);
        cfg_auto = 0;
        pulse_clr();
    endtask

    initial begin
        rst = 1'b1;
        cfg_seq = '0; cfg_len_m1 = '0; cfg_off = '0; cfg_smp = '0;
        cfg_res = '0; cfg_edge = '0; cfg_sw_only = 1'b1; cfg_scan = 1'b1;
        cfg_disc = 1'b0; cfg_auto = 1'b0;
        sw_start = 1'b0; ext_trig = 1'b0; reg_done = 1'b0; eos_clr = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_seq();
        t_short_len();
        t_res_offset(2, 'h1F3, "8-bit");
        t_res_offset(3, 'h07F, "6-bit");
        t_res_offset(1, 'hFFF, "10-bit");
        t_res_offset(0, 'h123, "12-bit");
        t_busy();
        t_edges();
        t_disc();
        t_scan_off();
        t_auto();
        report();
    end
endmodule